// File: doc/BRIEF.md
# Embedded Word-Boundary Deserializer

This block turns a source-synchronous serial stream back into parallel words. A slow serial clock and a serial data line are sampled by a fast system clock. Each rising edge of the serial clock shifts one payload bit in, and the first bit received lands in the least significant position. The end of a word is marked by the clock itself: instead of the usual short high phase, the serial clock stays high through two extra bit times, and during that stretch the data line carries two check bits. When the serial clock falls after such a stretch, the block takes the last 24 payload bits. It drops the two check bits and the two top payload bits, and after a fixed delay it presents 22 bits: 20 on the shared output and 2 on the dedicated output. At the same moment it drives a low pulse on the word clock.

The block does not need to be told the bit time. It measures the length of each low phase of the serial clock in system cycles. One bit time is two low-phase lengths, and every threshold and delay is scaled from that measurement. Idle zero bits may be sent between words. They pass through the shift register, and only the 24 bits that come just before a boundary are used.

Top module: `wbd_deser`

## Requirements
- R1: After reset, and until the first word is released, `par_o` and `ded_o` are all zero, `frame_err_o` is 0 and `wclk_o` is 1.
- R2: Payload bit n (1-based, in the order received) appears on `par_o[n-1]` for n = 1..20. Bits 21 and 22 appear on `ded_o[0]` and `ded_o[1]`. Bits 23 and 24 reach no output.
- R3: A boundary is recognised when a high phase of the serial clock lasts more than four low-phase lengths and then falls. In that case the 24 bits most recently shifted in on rising edges form the word.
- R4: `wclk_o` falls 12 low-phase lengths (6 bit times) after the serial-clock fall that ends the boundary, plus a fixed synchronizer latency of at most 6 system cycles.
- R5: `wclk_o` stays low for exactly 26 low-phase lengths (13 bit times) and then returns high.
- R6: A stream with no boundary produces no pulse on `wclk_o`, and the outputs keep their values. This includes a high phase of only three low-phase lengths.
- R7: `par_o`, `ded_o` and `frame_err_o` change only in the cycle in which `wclk_o` falls.
- R8: Idle bits sent between words are ignored. The interval between falls of `wclk_o` equals the word period, that is (26 + idle bits) bit times.
- R9: The first check bit is sampled two low-phase lengths after the last rising edge, and the second is sampled four low-phase lengths after it. `frame_err_o` is 1 for a word whose first check bit equals payload bit 24, or whose second check bit differs from payload bit 24. Otherwise it is 0. It is released together with the word.
- R10: The bit time is taken from the latest low phase, so words sent at different bit times decode correctly without reconfiguration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock with the embedded boundary |
| sdat_i | input | 1 | Serial data, valid around each rising edge of the serial clock |
| par_o | output | 20 | Shared parallel output, payload bits 1 to 20 |
| ded_o | output | 2 | Dedicated parallel output, payload bits 21 and 22 |
| wclk_o | output | 1 | Word clock, idles high and pulses low once for each word |
| frame_err_o | output | 1 | Check-bit mismatch flag for the word currently on the outputs |

## Verification
Two things overlap in time. While the previous word's delayed release and low pulse are still in progress, the first bits of the next word, or the idle bits after it, are already being shifted in. Each test word is therefore followed directly by 22 more serial bits. This makes shifting and release run side by side, and the released value, the measured delay and the pulse length are then compared with what the requirements give for the earlier word. A monitor also reports any output change that does not coincide with a fall of the word clock.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
  localparam int unsigned PAY_W    = 24;
  localparam int unsigned OUT_W    = 22;
  localparam int unsigned SHARED_W = 20;

  typedef enum logic [1:0] {
    WC_IDLE = 2'd0,
    WC_WAIT = 2'd1,
    WC_LOW  = 2'd2
  } wc_state_e;
endpackage

// File: rtl/wbd_sync.sv
module wbd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic lvl_o,
  output logic dat_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] ck_q, dt_q;
  logic              ck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q <= '0;
      dt_q <= '0;
      ck_d <= 1'b0;
    end else begin
      ck_q <= {ck_q[STAGES-2:0], sclk_i};
      dt_q <= {dt_q[STAGES-2:0], sdat_i};
      ck_d <= ck_q[STAGES-1];
    end
  end

  assign lvl_o  = ck_q[STAGES-1];
  assign dat_o  = dt_q[STAGES-1];
  assign rise_o = lvl_o & ~ck_d;
  assign fall_o = ~lvl_o & ck_d;
endmodule

// File: rtl/wbd_framer.sv
module wbd_framer #(
  parameter int unsigned PAY_W = 24,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             dat_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             cap_o,
  output logic [PAY_W-1:0] word_o,
  output logic             err_o,
  output logic [CNT_W-1:0] lo_len_o
);
  localparam int unsigned WIDE_W = CNT_W + 3;

  logic [CNT_W-1:0]  cnt_q, lo_len_q;
  logic [PAY_W-1:0]  sh_q;
  logic              chk1_q, chk2_q;
  logic [WIDE_W-1:0] cnt_w, two_lo, four_lo;

  assign cnt_w   = WIDE_W'(cnt_q);
  assign two_lo  = WIDE_W'(lo_len_q) << 1;
  assign four_lo = WIDE_W'(lo_len_q) << 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      lo_len_q <= '0;
      sh_q     <= '0;
      chk1_q   <= 1'b0;
      chk2_q   <= 1'b0;
      cap_o    <= 1'b0;
      word_o   <= '0;
      err_o    <= 1'b0;
    end else begin
      cap_o <= 1'b0;
      if (rise_i || fall_i)  cnt_q <= CNT_W'(1);
      else if (cnt_q != '1)  cnt_q <= cnt_q + 1'b1;

      if (rise_i) begin
        lo_len_q <= cnt_q;
        sh_q     <= {dat_i, sh_q[PAY_W-1:1]};
      end else if (lvl_i) begin
        // check bits sampled mid-bit within the stretched high phase
        if (cnt_w == two_lo)  chk1_q <= dat_i;
        if (cnt_w == four_lo) chk2_q <= dat_i;
      end

      if (fall_i && lo_len_q != '0 && cnt_w > four_lo) begin
        cap_o  <= 1'b1;
        word_o <= sh_q;
        err_o  <= (chk1_q == sh_q[PAY_W-1]) | (chk2_q != sh_q[PAY_W-1]);
      end
    end
  end

  assign lo_len_o = lo_len_q;

  // R3
  cap_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> !lvl_i);
  // R10
  cap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> lo_len_q != '0);
endmodule

// File: rtl/wbd_wclk.sv
module wbd_wclk
  import wbd_pkg::*;
#(
  parameter int unsigned PAY_W    = 24,
  parameter int unsigned OUT_W    = 22,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DLY_BITS = 6,
  parameter int unsigned LOW_BITS = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [PAY_W-1:0] word_i,
  input  logic             err_i,
  input  logic [CNT_W-1:0] lo_len_i,
  output logic             wclk_o,
  output logic [OUT_W-1:0] out_o,
  output logic             err_o
);
  localparam int unsigned TMR_W = CNT_W + 6;

  wc_state_e        st_q;
  logic [TMR_W-1:0] tmr_q, dly_len, low_len, low_run_q;
  logic [OUT_W-1:0] hold_q;
  logic             hold_err_q;
  logic [CNT_W-1:0] hold_lo_q;

  assign dly_len = TMR_W'(lo_len_i)  * TMR_W'(2 * DLY_BITS);
  assign low_len = TMR_W'(hold_lo_q) * TMR_W'(2 * LOW_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= WC_IDLE;
      tmr_q      <= '0;
      hold_q     <= '0;
      hold_err_q <= 1'b0;
      hold_lo_q  <= '0;
      wclk_o     <= 1'b1;
      out_o      <= '0;
      err_o      <= 1'b0;
    end else if (cap_i) begin
      st_q       <= WC_WAIT;
      tmr_q      <= dly_len;
      hold_q     <= word_i[OUT_W-1:0];
      hold_err_q <= err_i;
      hold_lo_q  <= lo_len_i;
      wclk_o     <= 1'b1;
    end else begin
      case (st_q)
        WC_WAIT: begin
          if (tmr_q == TMR_W'(1)) begin
            st_q   <= WC_LOW;
            tmr_q  <= low_len;
            wclk_o <= 1'b0;
            out_o  <= hold_q;
            err_o  <= hold_err_q;
          end else tmr_q <= tmr_q - 1'b1;
        end
        WC_LOW: begin
          if (tmr_q == TMR_W'(1)) begin
            st_q   <= WC_IDLE;
            wclk_o <= 1'b1;
          end else tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= WC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      low_run_q <= '0;
    else if (!wclk_o) low_run_q <= low_run_q + 1'b1;
    else              low_run_q <= '0;
  end

  // R5
  low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wclk_o |-> low_run_q < low_len);
  // R4
  fall_after_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wclk_o) |-> $past(st_q) == WC_WAIT);
  // R7
  out_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_o) |-> $fell(wclk_o));
endmodule

// File: rtl/wbd_deser.sv
module wbd_deser
  import wbd_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                sdat_i,
  output logic [SHARED_W-1:0] par_o,
  output logic [OUT_W-SHARED_W-1:0] ded_o,
  output logic                wclk_o,
  output logic                frame_err_o
);
  logic             lvl, dat, rise, fall, cap, cap_err;
  logic [PAY_W-1:0] cap_word;
  logic [CNT_W-1:0] lo_len;
  logic [OUT_W-1:0] out_w;

  wbd_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .sdat_i,
    .lvl_o(lvl), .dat_o(dat), .rise_o(rise), .fall_o(fall)
  );

  wbd_framer #(.PAY_W(PAY_W), .CNT_W(CNT_W)) u_framer (
    .clk_i, .rst_ni, .lvl_i(lvl), .dat_i(dat), .rise_i(rise), .fall_i(fall),
    .cap_o(cap), .word_o(cap_word), .err_o(cap_err), .lo_len_o(lo_len)
  );

  wbd_wclk #(.PAY_W(PAY_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_wclk (
    .clk_i, .rst_ni, .cap_i(cap), .word_i(cap_word), .err_i(cap_err),
    .lo_len_i(lo_len), .wclk_o(wclk_o), .out_o(out_w), .err_o(frame_err_o)
  );

  assign par_o = out_w[SHARED_W-1:0];
  assign ded_o = out_w[OUT_W-1:SHARED_W];
endmodule

// File: tb/wbd_deser_tb.sv
module wbd_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        sdat = 1'b0;
  logic [19:0] par;
  logic [1:0]  ded;
  logic        wclk, ferr;

  int cyc = 0, checks = 0, fails = 0;
  int h = 4;
  int falls = 0, fall_at = 0, prev_fall_at = 0, low_start = 0, last_low = 0;
  int bfall_cyc = 0, viol = 0;
  bit pend_b = 0;
  logic        wclk_p = 1'b1;
  logic [22:0] outs_p = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wbd_deser dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdat_i(sdat),
    .par_o(par), .ded_o(ded), .wclk_o(wclk), .frame_err_o(ferr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wclk_p && !wclk) begin
        falls++;
        prev_fall_at = fall_at;
        fall_at = cyc;
        low_start = cyc;
      end
      if (!wclk_p && wclk) last_low = cyc - low_start;
      // R7: outputs move only together with a word-clock fall
      if ({ferr, ded, par} != outs_p && !(wclk_p && !wclk)) viol++;
    end
    wclk_p = wclk;
    outs_p = {ferr, ded, par};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic d, input int n);
    sclk = s;
    sdat = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    if (pend_b) begin
      bfall_cyc = cyc;
      pend_b = 0;
    end
    drive(1'b0, b, h);
    drive(1'b1, b, h);
  endtask

  task automatic send_word(input logic [23:0] w, input bit bad1, input bit bad2, input int gap);
    for (int i = 0; i < 24; i++) send_bit(w[i]);
    drive(1'b1, ~w[23] ^ bad1, 2 * h);
    drive(1'b1, w[23] ^ bad2, 2 * h);
    pend_b = 1;
    for (int i = 0; i < gap; i++) send_bit(1'b0);
  endtask

  task automatic t_word(input logic [23:0] w, input bit bad1, input bit bad2, input string tag);
    int n0, dly;
    n0 = falls;
    send_word(w, bad1, bad2, 22);
    dly = fall_at - bfall_cyc;
    chk(falls == n0 + 1, {tag, " R3 one pulse per boundary"}, falls - n0, 1);
    chk(dly >= 12 * h && dly <= 12 * h + 6, {tag, " R4 fall delay"}, dly, 12 * h);
    chk(last_low == 26 * h, {tag, " R5 low time"}, last_low, 26 * h);
    chk(par == w[19:0], {tag, " R2 shared bits"}, par, w[19:0]);
    chk(ded == w[21:20], {tag, " R2 dedicated bits"}, ded, w[21:20]);
    chk(ferr == (bad1 | bad2), {tag, " R9 check-bit flag"}, ferr, bad1 | bad2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(par == 0 && ded == 0, "R1 outputs zero after reset", {ded, par}, 0);
    chk(wclk == 1'b1, "R1 word clock high", wclk, 1);
    chk(ferr == 1'b0, "R1 flag low", ferr, 0);
  endtask

  task automatic t_no_boundary;
    int n0;
    n0 = falls;
    for (int i = 0; i < 40; i++) send_bit(logic'(i % 3 == 0));
    drive(1'b0, 1'b1, h);
    drive(1'b1, 1'b1, 3 * h);
    for (int i = 0; i < 30; i++) send_bit(1'b1);
    chk(falls == n0, "R6 no pulse without boundary", falls - n0, 0);
    chk(par == 0 && ded == 0, "R6 R1 outputs still zero", {ded, par}, 0);
    chk(wclk == 1'b1, "R6 word clock stays high", wclk, 1);
  endtask

  task automatic t_idle_gap;
    int per;
    for (int i = 0; i < 9; i++) send_bit(1'b0);
    t_word(24'h5A3C96, 0, 0, "gapA");
    t_word(24'h0F0F0F, 0, 0, "gapB");
    per = fall_at - prev_fall_at;
    // R8: 24 payload + 2 check + 22 idle bits, two low lengths each
    chk(per == (26 + 22) * 2 * h, "R8 word-clock period", per, (26 + 22) * 2 * h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_no_boundary();
    t_word(24'h3FFFFF, 0, 0, "ones");
    t_word(24'hC12345, 0, 0, "top bits dropped");
    t_word(24'hAAAAAA, 0, 0, "alternating");
    t_word(24'h800001, 1, 0, "bad first check bit");
    t_word(24'h400002, 0, 1, "bad second check bit");
    t_word(24'h800001, 0, 0, "good check bits");
    h = 5;
    t_word(24'h2468AC, 0, 0, "R10 slow");
    h = 3;
    t_word(24'h13579B, 0, 0, "R10 fast");
    h = 4;
    t_idle_gap();
    chk(viol == 0, "R7 output change off word-clock fall", viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule